// File: doc/BRIEF.md
# DMA Request Cause Selector

This block sits in front of one DMA channel and decides which event starts a transfer. Software writes an 8-bit configuration register that holds a 4-bit cause code, an expansion bit and a write-only software request bit. The block watches sixteen interrupt-request strobes from the timers, UARTs, serial I/O units and the A-D converter, together with a raw external interrupt pin. It turns the one selected event into a request pulse, exactly one clock wide, for the channel controller.

Each strobe goes through its own rising-edge detector before selection. A strobe that stays high therefore raises one request only, and changing the cause code never turns a level that is already present into a request. The external pin is asynchronous. It passes through a synchronizer chain and a previous-sample flop, which produce a falling-edge event and an any-edge event. The expansion bit sends three of the cause codes to alternative sources. The deassertion of `rst_n` is expected to be synchronous to `clk`.

Top module: `dmasel_top`

## Requirements
- R1: After reset the register reads 0x00 and `dma_req` is low.
- R2: A write stores `reg_wdata[3:0]` as the cause code and `reg_wdata[6]` as the expansion bit. `reg_rdata` shows them in the same positions on the cycle after the write, and bits 7, 5 and 4 always read 0.
- R3: A rising edge on the selected timer strobe gives one `dma_req` pulse in the cycle after the edge is sampled. Codes 2, 3 and 4 select `tmr_a_irq[0..2]`, and codes 8 and 9 select `tmr_b_irq[1]` and `tmr_b_irq[2]`. With the expansion bit at 0, codes 5, 6 and 7 select `tmr_a_irq[3]`, `tmr_a_irq[4]` and `tmr_b_irq[0]`.
- R4: With the expansion bit at 1, code 5 selects `sio_irq[0]` and code 6 selects `sio_irq[1]`, and the timers those codes normally select are ignored. Code 7 requests on both edges of `ext_pin`.
- R5: Code 10 selects `uart_tx_irq[0]`, 11 selects `uart_rx_irq[0]`, 12 selects `uart_tx_irq[2]`, 13 selects `uart_rx_irq[1]`, 14 selects `adc_irq` and 15 selects `uart_tx_irq[1]`.
- R6: Code 0 requests on a falling edge of `ext_pin`. The pulse appears on the third clock edge after the pin changes, and rising edges are ignored.
- R7: A write with `reg_wdata[7]`=1 whose own cause field is 1 requests on the next cycle. With any other cause field, bit 7 has no effect, and bit 7 always reads back as 0.
- R8: A strobe held high for several cycles gives exactly one single-cycle pulse.
- R9: Strobes that are not selected give no request. Moving the cause code onto a strobe that is already high gives no request.
- R10: The expansion bit has no effect on codes other than 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tmr_a_irq | input | 5 | Timer A0..A4 request strobes |
| tmr_b_irq | input | 3 | Timer B0..B2 request strobes |
| uart_tx_irq | input | 3 | UART0, UART1, UART2 transmit strobes |
| uart_rx_irq | input | 2 | UART0 (bit 0), UART2 (bit 1) receive strobes |
| sio_irq | input | 2 | Serial I/O 3 (bit 0), 4 (bit 1) strobes |
| adc_irq | input | 1 | A-D conversion end strobe |
| ext_pin | input | 1 | Raw asynchronous external interrupt pin |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
The hardest case to reach from the ports is a selection change that lands on a source whose strobe is already high. A wrong design would raise a request there because of the level and not because of an edge. The stimulus holds one timer strobe high across several cycles and rewrites the cause code onto it in the middle of that window. The scoreboard has no entry queued for that moment, so any pulse counts as a failure. The pin tests use the same queue, with the three-cycle synchronizer delay built into each expected entry, for both falling-edge and any-edge selection.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;
  localparam int CAUSE_W = 4;
  localparam int NUM_SRC = 16;
  localparam int REG_W   = 8;
  localparam int BIT_SW  = 7;
  localparam int BIT_EXP = 6;

  typedef enum logic [CAUSE_W-1:0] {
    CS_PIN_FALL  = 4'd0,
    CS_SOFT      = 4'd1,
    CS_TA0       = 4'd2,
    CS_TA1       = 4'd3,
    CS_TA2       = 4'd4,
    CS_TA3_SIO3  = 4'd5,
    CS_TA4_SIO4  = 4'd6,
    CS_TB0_PIN2E = 4'd7,
    CS_TB1       = 4'd8,
    CS_TB2       = 4'd9,
    CS_U0TX      = 4'd10,
    CS_U0RX      = 4'd11,
    CS_U2TX      = 4'd12,
    CS_U2RX      = 4'd13,
    CS_ADC       = 4'd14,
    CS_U1TX      = 4'd15
  } cause_e;

  // positions in the packed strobe vector
  localparam int SRC_TA0  = 0;
  localparam int SRC_TA1  = 1;
  localparam int SRC_TA2  = 2;
  localparam int SRC_TA3  = 3;
  localparam int SRC_TA4  = 4;
  localparam int SRC_TB0  = 5;
  localparam int SRC_TB1  = 6;
  localparam int SRC_TB2  = 7;
  localparam int SRC_U0TX = 8;
  localparam int SRC_U0RX = 9;
  localparam int SRC_U2TX = 10;
  localparam int SRC_U2RX = 11;
  localparam int SRC_ADC  = 12;
  localparam int SRC_U1TX = 13;
  localparam int SRC_SIO3 = 14;
  localparam int SRC_SIO4 = 15;

  typedef struct packed {
    logic   expand;
    cause_e cause;
  } cfg_t;
endpackage

// File: rtl/dmasel_cfg_reg.sv
module dmasel_cfg_reg
  import dmasel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic             sw_hit,
  output logic [REG_W-1:0] rdata
);
  cfg_t cfg_q;
  cfg_t cfg_d;
  logic unused_wbits;

  assign unused_wbits = &{1'b0, wdata[5:4]};

  always_comb begin
    cfg_d.expand = wdata[BIT_EXP];
    cfg_d.cause  = cause_e'(wdata[CAUSE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  // software trigger judged on the cause carried by the same write
  always_comb begin
    sw_hit = wr_en && wdata[BIT_SW] && (wdata[CAUSE_W-1:0] == CS_SOFT);
  end

  always_comb begin
    rdata                = '0;
    rdata[CAUSE_W-1:0]   = cfg_q.cause;
    rdata[BIT_EXP]       = cfg_q.expand;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/dmasel_pin_edge.sv
module dmasel_pin_edge #(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall,
  output logic any_edge
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      logic stage_d;
      if (i == 0) begin : g_first
        assign stage_d = pin;
      end else begin : g_next
        assign stage_d = sync_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= PIN_IDLE;
        else        sync_q[i] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PIN_IDLE;
    else        prev_q <= sync_q[LAST];
  end

  always_comb begin
    fall     = prev_q & ~sync_q[LAST];
    any_edge = prev_q ^ sync_q[LAST];
  end
endmodule

// File: rtl/dmasel_src_sel.sv
module dmasel_src_sel
  import dmasel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  input  logic [NUM_SRC-1:0] strb,
  input  logic               pin_fall,
  input  logic               pin_any,
  input  logic               sw_hit,
  output logic               req
);
  logic [NUM_SRC-1:0] strb_q;
  logic [NUM_SRC-1:0] rise;
  logic               req_d;
  logic               req_q;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q[s] <= 1'b0;
        else        strb_q[s] <= strb[s];
      end
      assign rise[s] = strb[s] & ~strb_q[s];
    end
  endgenerate

  always_comb begin
    req_d = 1'b0;
    unique case (cfg.cause)
      CS_PIN_FALL:  req_d = pin_fall;
      CS_SOFT:      req_d = 1'b0;
      CS_TA0:       req_d = rise[SRC_TA0];
      CS_TA1:       req_d = rise[SRC_TA1];
      CS_TA2:       req_d = rise[SRC_TA2];
      CS_TA3_SIO3:  req_d = cfg.expand ? rise[SRC_SIO3] : rise[SRC_TA3];
      CS_TA4_SIO4:  req_d = cfg.expand ? rise[SRC_SIO4] : rise[SRC_TA4];
      CS_TB0_PIN2E: req_d = cfg.expand ? pin_any        : rise[SRC_TB0];
      CS_TB1:       req_d = rise[SRC_TB1];
      CS_TB2:       req_d = rise[SRC_TB2];
      CS_U0TX:      req_d = rise[SRC_U0TX];
      CS_U0RX:      req_d = rise[SRC_U0RX];
      CS_U2TX:      req_d = rise[SRC_U2TX];
      CS_U2RX:      req_d = rise[SRC_U2RX];
      CS_ADC:       req_d = rise[SRC_ADC];
      CS_U1TX:      req_d = rise[SRC_U1TX];
      default:      req_d = 1'b0;
    endcase
    req_d = req_d | sw_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/dmasel_top.sv
module dmasel_top
  import dmasel_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [4:0] tmr_a_irq,
  input  logic [2:0] tmr_b_irq,
  input  logic [2:0] uart_tx_irq,
  input  logic [1:0] uart_rx_irq,
  input  logic [1:0] sio_irq,
  input  logic       adc_irq,
  input  logic       ext_pin,
  output logic       dma_req
);
  cfg_t               cfg;
  logic               sw_hit;
  logic               pin_fall;
  logic               pin_any;
  logic [NUM_SRC-1:0] strb;

  assign strb = {sio_irq[1], sio_irq[0], uart_tx_irq[1], adc_irq,
                 uart_rx_irq[1], uart_tx_irq[2], uart_rx_irq[0], uart_tx_irq[0],
                 tmr_b_irq, tmr_a_irq};

  dmasel_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .wdata  (reg_wdata),
    .cfg    (cfg),
    .sw_hit (sw_hit),
    .rdata  (reg_rdata)
  );

  dmasel_pin_edge #(
    .SYNC_STAGES (SYNC_STAGES),
    .PIN_IDLE    (PIN_IDLE)
  ) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .fall     (pin_fall),
    .any_edge (pin_any)
  );

  dmasel_src_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .strb     (strb),
    .pin_fall (pin_fall),
    .pin_any  (pin_any),
    .sw_hit   (sw_hit),
    .req      (dma_req)
  );
endmodule

// File: rtl/dmasel_chk.sv
module dmasel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [4:0] tmr_a_irq,
  input logic       dma_req
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reg_rdata == 8'h00) && !dma_req);

  a_r2_write_back: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata == {1'b0, $past(reg_wdata[6]), 2'b00, $past(reg_wdata[3:0])});

  a_r3_timer_edge: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && reg_rdata[3:0] == 4'd2 && tmr_a_irq[0] && !$past(tmr_a_irq[0]) |=> dma_req);

  a_r7_soft_request: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[7] && reg_wdata[3:0] == 4'd1 |=> dma_req);

  a_r8_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !reg_wr && reg_rdata[3:0] == 4'd2 && tmr_a_irq[0] && $past(tmr_a_irq[0])
    |=> !dma_req);
endmodule

bind dmasel_top dmasel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tmr_a_irq (tmr_a_irq),
  .dma_req   (dma_req)
);

// File: tb/tb_dmasel_top.sv
`timescale 1ns/1ps
module tb_dmasel_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] src;
  logic        ext_pin;
  logic        dma_req;

  int    cyc = 0;
  int    checks = 0;
  int    bad = 0;
  bit    mon_on = 0;
  bit    done = 0;
  string phase = "R1";
  int    qc[$];
  string qt[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmasel_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tmr_a_irq   (src[4:0]),
    .tmr_b_irq   (src[7:5]),
    .uart_tx_irq ({src[10], src[13], src[8]}),
    .uart_rx_irq ({src[11], src[9]}),
    .sio_irq     (src[15:14]),
    .adc_irq     (src[12]),
    .ext_pin     (ext_pin),
    .dma_req     (dma_req)
  );

  // bench source numbering: 0-4 timer A0-A4, 5-7 timer B0-B2, 8 uart0 tx,
  // 9 uart0 rx, 10 uart2 tx, 11 uart2 rx, 12 adc, 13 uart1 tx, 14 sio3, 15 sio4
  function automatic int src_for(int code, bit ex);
    case (code)
      2: return 0;  3: return 1;  4: return 2;
      5: return ex ? 14 : 3;
      6: return ex ? 15 : 4;
      7: return ex ? -1 : 5;
      8: return 6;  9: return 7;
      10: return 8; 11: return 9; 12: return 10; 13: return 11;
      14: return 12; 15: return 13;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_for(int code);
    if (code >= 10) return "R5";
    return "R3";
  endfunction

  task automatic push(int c, string t);
    qc.push_back(c);
    qt.push_back(t);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", t, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, string t);
    phase = t;
    reg_wr = 1'b1;
    reg_wdata = d;
    if (d[7] && d[3:0] == 4'd1) push(cyc + 1, t);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic strobe(int idx, bit expect_req, string t);
    phase = t;
    src[idx] = 1'b1;
    if (expect_req) push(cyc + 1, t);
    @(negedge clk);
    src[idx] = 1'b0;
    idle(2);
  endtask

  task automatic pin_set(logic v, bit expect_req, string t);
    phase = t;
    ext_pin = v;
    if (expect_req) push(cyc + 3, t);
    idle(6);
  endtask

  // monitor: pops the scoreboard when the design answers
  always @(negedge clk) begin
    if (mon_on) begin
      if (qc.size() > 0 && qc[0] < cyc) begin
        checks++; bad++;
        $display("FAIL %s: actual=no pulse expected=pulse at cycle %0d", qt[0], qc[0]);
        void'(qc.pop_front()); void'(qt.pop_front());
      end
      if (qc.size() > 0 && qc[0] == cyc) begin
        checks++;
        if (dma_req !== 1'b1) begin
          bad++;
          $display("FAIL %s: actual=%b expected=1", qt[0], dma_req);
        end
        void'(qc.pop_front()); void'(qt.pop_front());
      end else if (dma_req !== 1'b0) begin
        checks++; bad++;
        $display("FAIL %s: actual=%b expected=0 (unexpected request)", phase, dma_req);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00; src = '0; ext_pin = 1'b1;
    idle(3);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1 reset state
    chk8("R1 reset rdata", reg_rdata, 8'h00);
    chk8("R1 reset req", {7'd0, dma_req}, 8'h00);
    idle(2);

    // R2 readback, reserved bits zero; cause 15 so bit 7 makes no request (R7)
    wr(8'hFF, "R2");
    chk8("R2 readback", reg_rdata, 8'h4F);
    wr(8'h35, "R2");
    chk8("R2 readback reserved", reg_rdata, 8'h05);

    // R3/R5 every peripheral code with expansion 0, plus an unselected source (R9)
    for (int code = 2; code < 16; code++) begin
      int s;
      s = src_for(code, 1'b0);
      wr(8'(code), tag_for(code));
      strobe(s, 1'b1, tag_for(code));
      strobe((s + 1) % 16, 1'b0, "R9");
    end

    // R4 expanded sources; normal timers ignored
    wr(8'h45, "R4");
    strobe(14, 1'b1, "R4");
    strobe(3, 1'b0, "R4");
    wr(8'h46, "R4");
    strobe(15, 1'b1, "R4");
    strobe(4, 1'b0, "R4");
    wr(8'h47, "R4");
    strobe(5, 1'b0, "R4");
    pin_set(1'b0, 1'b1, "R4");
    pin_set(1'b1, 1'b1, "R4");

    // R10 expansion bit on other codes
    wr(8'h42, "R10");
    strobe(0, 1'b1, "R10");
    wr(8'h4E, "R10");
    strobe(12, 1'b1, "R10");
    wr(8'h48, "R10");
    strobe(6, 1'b1, "R10");

    // R3 code 7 without expansion: pin ignored, timer B0 used
    wr(8'h07, "R3");
    pin_set(1'b0, 1'b0, "R3");
    pin_set(1'b1, 1'b0, "R3");
    strobe(5, 1'b1, "R3");

    // R6 falling edge only
    wr(8'h00, "R6");
    pin_set(1'b0, 1'b1, "R6");
    pin_set(1'b1, 1'b0, "R6");
    pin_set(1'b0, 1'b1, "R6");
    pin_set(1'b1, 1'b0, "R6");

    // R7 software trigger
    wr(8'h81, "R7");
    idle(2);
    chk8("R7 bit7 reads 0", reg_rdata, 8'h01);
    wr(8'h82, "R7");
    idle(2);
    chk8("R7 no-trigger readback", reg_rdata, 8'h02);
    wr(8'hC1, "R7");
    idle(2);
    chk8("R7 readback expanded", reg_rdata, 8'h41);
    wr(8'h01, "R7");
    idle(3);

    // R8 held strobe gives one pulse
    wr(8'h02, "R8");
    phase = "R8";
    src[0] = 1'b1;
    push(cyc + 1, "R8");
    idle(6);
    src[0] = 1'b0;
    idle(2);

    // R9 select moves onto a strobe that is already high
    phase = "R9";
    src[1] = 1'b1;
    idle(2);
    wr(8'h03, "R9");
    idle(5);
    src[1] = 1'b0;
    idle(3);
    strobe(1, 1'b1, "R9");

    idle(6);
    checks++;
    if (qc.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", qc.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule